// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This controller paces the digital side of a successive-approximation converter. An active-low start input is watched for a high-to-low transition. That transition freezes the input sample and opens a conversion window. During the window `busy` is high. The length of the window depends on the timing mode, and the mode is chosen by two select pins. When the window closes, the word on `result_in` is captured into the output register. A one-cycle `done_stb` pulse tells the readout port that new data is waiting. An acquisition window of fixed length follows, during which the sampler tracks the input again. The real bit trials are not modelled: the conversion is a down-counter of fixed length, and the bench supplies the result word.

There are three timing modes. The warp mode is the fastest and is chosen only when `warp_sel` is high and `impulse_sel` is low. The impulse mode is the low-power mode and is chosen only when `impulse_sel` is high and `warp_sel` is low. Any other pin combination gives the normal mode. In impulse mode, a start input that is still low when acquisition ends launches the next conversion without a new edge. The power-down input lets the running conversion finish and then blocks further conversions. The asynchronous reset aborts a conversion at once and leaves the stored result untouched.

The state machine has three states:
- `ST_IDLE` moves to `ST_CONV` on a start edge when power-down is low.
- `ST_CONV` moves to `ST_ACQ` when its timer expires, which also latches the result and fires the strobe.
- `ST_ACQ` moves to `ST_CONV` when its timer expires in impulse mode with the start input low and power-down low. Otherwise it moves back to `ST_IDLE`.
- Reset forces `ST_IDLE` from any state.

Top module: `sar_conv_ctrl`

## Requirements
- R1: While `rst` is high, `busy`, `acquiring` and `done_stb` are low. This takes effect immediately, without waiting for a clock edge.
- R2: A start edge is `start_n` sampled low on a clock edge after being sampled high on the previous edge. When a start edge is seen in the idle state, `busy` is high from that edge onward.
- R3: `busy` stays high for exactly CONV_NORMAL (12) cycles in normal mode, CONV_WARP (8) cycles in warp mode and CONV_IMPULSE (14) cycles in impulse mode. Both selects high gives normal mode.
- R4: In the first cycle after `busy` falls, `done_stb` is high for exactly one cycle and `data_out` equals the `result_in` value that was held through the conversion.
- R5: `acquiring` is high for exactly ACQ_CYC (4) cycles right after each completed conversion. A start edge during acquisition is ignored.
- R6: A start edge while `busy` is high is ignored: it neither lengthens the conversion nor queues another one.
- R7: In impulse mode, if `start_n` is low and `pwr_down` is low at the end of acquisition, `busy` rises again in the next cycle without a new start edge. The new conversion completes with its own strobe and data.
- R8: Outside impulse mode, a `start_n` held low through the end of acquisition leaves the block idle.
- R9: `pwr_down` high lets a running conversion complete with strobe and data. While it is high, start edges and the impulse restart are both blocked, including when it rises in the final acquisition cycle.
- R10: Raising `rst` during a conversion drops `busy` at once, gives no `done_stb`, and leaves `data_out` at the last completed result.
- R11: A `start_n` held low through the release of reset is not a start edge. It must first be seen high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Asynchronous active-high reset; aborts a conversion |
| start_n | input | 1 | Active-low conversion request; its falling edge starts a conversion |
| warp_sel | input | 1 | Fast-mode select |
| impulse_sel | input | 1 | Low-power-mode select |
| pwr_down | input | 1 | Blocks new conversions once the current one has finished |
| result_in | input | RES_W (16) | Converted word presented by the bit-trial model |
| busy | output | 1 | High during the conversion window |
| acquiring | output | 1 | High during the acquisition window |
| data_out | output | RES_W (16) | Latched conversion result |
| done_stb | output | 1 | One-cycle pulse when a result has been latched |

## Verification
The tightest collision is the impulse auto-restart and power-down landing on the same clock edge. The bench keeps `start_n` low in impulse mode and raises `pwr_down` at the last sampling point of acquisition, so that the restart decision and the inhibit are evaluated together. It then expects `busy` and `acquiring` to be low on the following cycle. A second collision is a reset arriving mid-conversion while the timer is running. It is judged by `busy` dropping before the next clock edge, by the absence of a strobe, and by the unchanged `data_out`.

// File: rtl/sar_ctrl_pkg.sv
package sar_ctrl_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CONV = 2'd1,
        ST_ACQ  = 2'd2
    } sar_state_t;

    typedef enum logic [1:0] {
        MODE_NORMAL  = 2'd0,
        MODE_WARP    = 2'd1,
        MODE_IMPULSE = 2'd2
    } sar_mode_t;

endpackage

// File: rtl/sar_start_detect.sv
module sar_start_detect (
    input  logic clk,
    input  logic rst,
    input  logic start_n,
    output logic start_fall
);

    logic start_q;

    // Cleared on reset: a level held low out of reset must be seen high first.
    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            start_q <= 1'b0;
        end else begin
            start_q <= start_n;
        end
    end

    assign start_fall = start_q & ~start_n;

endmodule

// File: rtl/sar_mode_decode.sv
module sar_mode_decode
    import sar_ctrl_pkg::*;
#(
    parameter int CNT_W        = 4,
    parameter int CONV_NORMAL  = 12,
    parameter int CONV_WARP    = 8,
    parameter int CONV_IMPULSE = 14
) (
    input  logic             warp_sel,
    input  logic             impulse_sel,
    output sar_mode_t        mode,
    output logic [CNT_W-1:0] conv_last
);

    localparam logic [CNT_W-1:0] LAST_NORMAL  = CNT_W'(CONV_NORMAL - 1);
    localparam logic [CNT_W-1:0] LAST_WARP    = CNT_W'(CONV_WARP - 1);
    localparam logic [CNT_W-1:0] LAST_IMPULSE = CNT_W'(CONV_IMPULSE - 1);

    always_comb begin
        unique case ({warp_sel, impulse_sel})
            2'b10:   mode = MODE_WARP;
            2'b01:   mode = MODE_IMPULSE;
            default: mode = MODE_NORMAL;
        endcase
    end

    always_comb begin
        unique case (mode)
            MODE_WARP:    conv_last = LAST_WARP;
            MODE_IMPULSE: conv_last = LAST_IMPULSE;
            default:      conv_last = LAST_NORMAL;
        endcase
    end

endmodule

// File: rtl/sar_phase_timer.sv
module sar_phase_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign expired = (cnt == '0);

    // R5
    timer_rest_chk: assert property (@(posedge clk) disable iff (rst)
        (expired && !load) |=> expired);

endmodule

// File: rtl/sar_conv_ctrl.sv
module sar_conv_ctrl
    import sar_ctrl_pkg::*;
#(
    parameter int RES_W        = 16,
    parameter int CONV_NORMAL  = 12,
    parameter int CONV_WARP    = 8,
    parameter int CONV_IMPULSE = 14,
    parameter int ACQ_CYC      = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_n,
    input  logic             warp_sel,
    input  logic             impulse_sel,
    input  logic             pwr_down,
    input  logic [RES_W-1:0] result_in,
    output logic             busy,
    output logic             acquiring,
    output logic [RES_W-1:0] data_out,
    output logic             done_stb
);

    localparam int MAX_CONV = (CONV_NORMAL > CONV_WARP)
                            ? ((CONV_NORMAL > CONV_IMPULSE) ? CONV_NORMAL : CONV_IMPULSE)
                            : ((CONV_WARP > CONV_IMPULSE) ? CONV_WARP : CONV_IMPULSE);
    localparam int MAX_LEN  = (MAX_CONV > ACQ_CYC) ? MAX_CONV : ACQ_CYC;
    localparam int CNT_W    = $clog2(MAX_LEN + 1);
    localparam logic [CNT_W-1:0] ACQ_LAST = CNT_W'(ACQ_CYC - 1);

    sar_state_t       state, state_nx;
    sar_mode_t        mode;
    logic [CNT_W-1:0] conv_last;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_load, tmr_expired;
    logic             start_fall, latch_now;
    logic [RES_W-1:0] data_q;

    sar_start_detect u_start (
        .clk        (clk),
        .rst        (rst),
        .start_n    (start_n),
        .start_fall (start_fall)
    );

    sar_mode_decode #(
        .CNT_W        (CNT_W),
        .CONV_NORMAL  (CONV_NORMAL),
        .CONV_WARP    (CONV_WARP),
        .CONV_IMPULSE (CONV_IMPULSE)
    ) u_mode (
        .warp_sel    (warp_sel),
        .impulse_sel (impulse_sel),
        .mode        (mode),
        .conv_last   (conv_last)
    );

    sar_phase_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    // State register
    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // Transitions
    always_comb begin
        state_nx  = state;
        tmr_load  = 1'b0;
        tmr_val   = conv_last;
        latch_now = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (start_fall && !pwr_down) begin
                    state_nx = ST_CONV;
                    tmr_load = 1'b1;
                end
            end
            ST_CONV: begin
                if (tmr_expired) begin
                    state_nx  = ST_ACQ;
                    tmr_load  = 1'b1;
                    tmr_val   = ACQ_LAST;
                    latch_now = 1'b1;
                end
            end
            ST_ACQ: begin
                if (tmr_expired) begin
                    if (mode == MODE_IMPULSE && !start_n && !pwr_down) begin
                        state_nx = ST_CONV;
                        tmr_load = 1'b1;
                    end else begin
                        state_nx = ST_IDLE;
                    end
                end
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // Outputs decoded from state
    always_comb begin
        busy      = (state == ST_CONV);
        acquiring = (state == ST_ACQ);
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            done_stb <= 1'b0;
        end else begin
            done_stb <= latch_now;
        end
    end

    // Result register is left out of reset so that an abort keeps the last word.
    always_ff @(posedge clk) begin
        if (latch_now) begin
            data_q <= result_in;
        end
    end

    assign data_out = data_q;

    // R4
    stb_after_busy_chk: assert property (@(posedge clk) disable iff (rst)
        done_stb |-> (!busy && $past(busy)));

    // R9
    pd_no_start_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> !$past(pwr_down));

    // R7
    restart_mode_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(busy) && $past(acquiring)) |->
            ($past(impulse_sel) && !$past(warp_sel) && !$past(start_n)));

    // R10
    data_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!done_stb && !$isunknown($past(data_out))) |-> $stable(data_out));

endmodule

// File: tb/tb_sar_conv_ctrl.sv
module tb_sar_conv_ctrl;

    localparam int RES_W   = 16;
    localparam int L_NORM  = 12;
    localparam int L_WARP  = 8;
    localparam int L_IMP   = 14;
    localparam int L_ACQ   = 4;

    logic             clk = 1'b0;
    logic             rst;
    logic             start_n;
    logic             warp_sel;
    logic             impulse_sel;
    logic             pwr_down;
    logic [RES_W-1:0] result_in;
    logic             busy;
    logic             acquiring;
    logic [RES_W-1:0] data_out;
    logic             done_stb;

    int n_chk  = 0;
    int n_fail = 0;
    logic [RES_W-1:0] last_val;

    always #10 clk = ~clk;

    sar_conv_ctrl dut (
        .clk         (clk),
        .rst         (rst),
        .start_n     (start_n),
        .warp_sel    (warp_sel),
        .impulse_sel (impulse_sel),
        .pwr_down    (pwr_down),
        .result_in   (result_in),
        .busy        (busy),
        .acquiring   (acquiring),
        .data_out    (data_out),
        .done_stb    (done_stb)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic count_busy(output int n);
        n = 0;
        while (busy && n < 1000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic count_acq(output int n);
        n = 0;
        while (acquiring && n < 1000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic quiet_check(input int cycles, input string req);
        int seen;
        seen = 0;
        for (int k = 0; k < cycles; k++) begin
            @(negedge clk);
            if (busy) seen++;
        end
        chk(seen == 0, req, seen, 0);
    endtask

    // R1, R11
    task automatic t_reset;
        rst = 1'b1; start_n = 1'b0; warp_sel = 1'b0; impulse_sel = 1'b0;
        pwr_down = 1'b0; result_in = '0;
        repeat (3) @(negedge clk);
        chk(busy == 1'b0 && acquiring == 1'b0, "R1 busy/acq in reset", {busy, acquiring}, 0);
        chk(done_stb == 1'b0, "R1 strobe in reset", done_stb, 0);
        rst = 1'b0;
        quiet_check(4, "R11 low start out of reset");
        start_n = 1'b1;
        @(negedge clk);
    endtask

    // R2, R3, R4, R5
    task automatic conv_one(input logic w, input logic i, input logic [RES_W-1:0] val,
                            input int exp_len, input string tag);
        int n;
        @(negedge clk);
        warp_sel = w; impulse_sel = i; result_in = val; start_n = 1'b0;
        @(negedge clk);
        chk(busy == 1'b1, "R2 busy after start edge", busy, 1);
        count_busy(n);
        chk(n == exp_len, tag, n, exp_len);
        chk(done_stb == 1'b1, "R4 strobe after busy falls", done_stb, 1);
        chk(data_out == val, "R4 latched data", data_out, val);
        start_n = 1'b1;
        @(negedge clk);
        chk(done_stb == 1'b0, "R4 strobe one cycle", done_stb, 0);
        count_acq(n);
        chk(n == L_ACQ - 1, "R5 acquisition length", n + 1, L_ACQ);
        chk(busy == 1'b0, "R5 idle after acquisition", busy, 0);
        last_val = val;
    endtask

    task automatic t_modes;
        conv_one(1'b0, 1'b0, 16'h1234, L_NORM, "R3 normal length");
        conv_one(1'b1, 1'b0, 16'hBEEF, L_WARP, "R3 warp length");
        conv_one(1'b0, 1'b1, 16'h00FF, L_IMP,  "R3 impulse length");
        conv_one(1'b1, 1'b1, 16'hFFFF, L_NORM, "R3 both selects normal");
    endtask

    // R6, R5, R8
    task automatic t_ignore;
        int n;
        @(negedge clk);
        warp_sel = 1'b0; impulse_sel = 1'b0; result_in = 16'hA5A5; start_n = 1'b0;
        @(negedge clk);
        repeat (3) @(negedge clk);
        start_n = 1'b1;
        @(negedge clk);
        start_n = 1'b0;
        count_busy(n);
        chk(n + 4 == L_NORM, "R6 edge while busy", n + 4, L_NORM);
        chk(data_out == 16'hA5A5, "R6 data", data_out, 16'hA5A5);
        start_n = 1'b1;
        @(negedge clk);
        start_n = 1'b0;
        count_acq(n);
        chk(n == L_ACQ - 1, "R5 edge during acquisition", n + 1, L_ACQ);
        quiet_check(6, "R8 held low no restart");
        start_n = 1'b1;
        last_val = 16'hA5A5;
        @(negedge clk);
    endtask

    // R7
    task automatic t_impulse;
        int n;
        @(negedge clk);
        warp_sel = 1'b0; impulse_sel = 1'b1; result_in = 16'h0F0F; start_n = 1'b0;
        @(negedge clk);
        count_busy(n);
        chk(n == L_IMP, "R7 first conversion", n, L_IMP);
        chk(data_out == 16'h0F0F, "R7 first data", data_out, 16'h0F0F);
        result_in = 16'hF0F0;
        count_acq(n);
        chk(n == L_ACQ, "R7 acquisition", n, L_ACQ);
        chk(busy == 1'b1, "R7 auto restart", busy, 1);
        count_busy(n);
        chk(n == L_IMP, "R7 second conversion", n, L_IMP);
        chk(done_stb == 1'b1 && data_out == 16'hF0F0, "R7 second data", data_out, 16'hF0F0);
        start_n = 1'b1;
        count_acq(n);
        quiet_check(3, "R7 stop after release");
        last_val = 16'hF0F0;
    endtask

    // R9
    task automatic t_powerdown;
        int n;
        @(negedge clk);
        warp_sel = 1'b0; impulse_sel = 1'b0; result_in = 16'h5555; start_n = 1'b0;
        @(negedge clk);
        repeat (5) @(negedge clk);
        pwr_down = 1'b1;
        count_busy(n);
        chk(n + 5 == L_NORM, "R9 conversion completes", n + 5, L_NORM);
        chk(done_stb == 1'b1 && data_out == 16'h5555, "R9 data", data_out, 16'h5555);
        start_n = 1'b1;
        count_acq(n);
        @(negedge clk);
        start_n = 1'b0;
        quiet_check(5, "R9 edge while powered down");
        start_n = 1'b1;
        pwr_down = 1'b0;
        // impulse restart versus power-down in the same cycle
        @(negedge clk);
        impulse_sel = 1'b1; result_in = 16'h7777; start_n = 1'b0;
        @(negedge clk);
        count_busy(n);
        chk(n == L_IMP, "R9 impulse conversion", n, L_IMP);
        repeat (L_ACQ - 1) @(negedge clk);
        chk(acquiring == 1'b1, "R9 last acquisition cycle", acquiring, 1);
        pwr_down = 1'b1;
        @(negedge clk);
        chk(busy == 1'b0 && acquiring == 1'b0, "R9 restart blocked", {busy, acquiring}, 0);
        quiet_check(3, "R9 stays idle");
        start_n = 1'b1;
        pwr_down = 1'b0;
        impulse_sel = 1'b0;
        last_val = 16'h7777;
        @(negedge clk);
    endtask

    // R10
    task automatic t_abort;
        int n;
        @(negedge clk);
        result_in = 16'h9999; start_n = 1'b0;
        @(negedge clk);
        repeat (3) @(negedge clk);
        chk(busy == 1'b1, "R10 busy before abort", busy, 1);
        rst = 1'b1;
        #1;
        chk(busy == 1'b0, "R10 busy drops at once", busy, 0);
        @(negedge clk);
        rst = 1'b0; start_n = 1'b1;
        n = 0;
        for (int k = 0; k < 15; k++) begin
            @(negedge clk);
            if (done_stb || busy) n++;
        end
        chk(n == 0, "R10 no strobe after abort", n, 0);
        chk(data_out == last_val, "R10 data kept", data_out, last_val);
        conv_one(1'b0, 1'b0, 16'h4321, L_NORM, "R10 normal after abort");
    endtask

    initial begin
        t_reset();
        t_modes();
        t_ignore();
        t_impulse();
        t_powerdown();
        t_abort();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 20000, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule